// File: doc/BRIEF.md
# SMBus Packet Error Code Engine

This block runs next to the byte-level datapath of an I2C/SMBus slave and looks after the Packet Error Code (PEC) of each transaction. Every byte that completes on the bus, including the address byte, is folded into a CRC-8. The CRC restarts at each start or repeated start. A loadable counter holds the number of data bytes still to come in the transaction, and that number includes the PEC byte. When PEC is enabled and exactly one byte remains, that byte is the PEC byte.

When the slave is sending, the engine replaces the application's byte with the CRC it has accumulated. When the slave is receiving, the engine compares the arriving byte against the CRC. On a mismatch it answers that byte with NAK and sets a sticky error flag. The engine also drives the active-low alert line. While an alert is raised it reports a hit on the Alert Response Address.

The host datapath pulses `start_i` for each start or repeated start. It pulses `byte_valid_i` for each completed byte, with the byte on `bus_byte_i` and the transfer direction on `byte_dir_i`. It takes the byte to transmit from `tx_byte_o` and takes the acknowledge decision from `ack_valid_o`/`nak_o`.

Top module: `smb_pec_engine`

## Requirements
- R1: After reset, `smbalert_n_o` is 1, and `pec_err_o`, `ack_valid_o`, `nak_o` and `ara_match_o` are 0. The remaining count is 0, so `tx_byte_o` equals `tx_data_i`.
- R2: The PEC is a CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first. It covers every byte strobed since the most recent `start_i`, including the address byte. A `start_i` clears it to 0x00.
- R3: The first byte after `start_i` is the address byte; address bit `bus_byte_i[7:1]`, direction bit `bus_byte_i[0]`. It is not counted. `cnt_load_i` sets the remaining count to `cnt_val_i`. Each later byte decrements the count, and the count stays at 0 once it reaches 0.
- R4: With `pec_en_i` high and a remaining count of 1, `tx_byte_o` equals the CRC of the bytes so far. Otherwise `tx_byte_o` equals `tx_data_i`.
- R5: For each received data byte (`byte_dir_i`=0), `ack_valid_o` pulses for one cycle, in the cycle after the strobe. In that pulse, `nak_o` is 1 only if PEC is enabled, the remaining count was 1, and the byte differs from the CRC.
- R6: A PEC mismatch sets `pec_err_o`. Only an `err_clr_i` pulse clears it, and a mismatch in the same cycle as a clear wins.
- R7: With `pec_en_i` low, no byte is substituted, no NAK is given and no error is set.
- R8: `smbalert_n_o` goes to 0 the cycle after `alert_i` goes high. It returns to 1 the cycle after `alert_i` goes low.
- R9: `ara_match_o` pulses for one cycle after an address byte with `bus_byte_i[7:1]` = 7'b0001100, but only while `alert_i` is high.
- R10: Transmitted bytes (`byte_dir_i`=1) and address bytes produce no `ack_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated start seen on the bus |
| byte_valid_i | input | 1 | One byte completed on the bus |
| byte_dir_i | input | 1 | 1: slave sent the byte, 0: slave received it |
| bus_byte_i | input | 8 | Byte that went over the bus |
| tx_data_i | input | 8 | Application's next byte to send |
| pec_en_i | input | 1 | PEC handling enabled |
| cnt_load_i | input | 1 | Load the remaining byte count |
| cnt_val_i | input | CNT_W | Byte count to load (data bytes plus PEC) |
| err_clr_i | input | 1 | Clear the sticky PEC error |
| alert_i | input | 1 | Raise the SMBus alert |
| tx_byte_o | output | 8 | Byte the slave must send next |
| ack_valid_o | output | 1 | Acknowledge decision valid for a received byte |
| nak_o | output | 1 | Answer the received byte with NAK |
| pec_err_o | output | 1 | Sticky PEC mismatch flag |
| smbalert_n_o | output | 1 | Active-low alert line |
| ara_match_o | output | 1 | Alert Response Address was addressed |

## Verification
The bench sends a received frame whose last byte is the correct PEC and expects ACK. If the address byte were counted, or the CRC did not start at the address, the check would land on the wrong byte and give a NAK. A corrupted PEC must give NAK and a sticky error that survives a later clean frame. A design that cleared the flag on its own, or never set it, would fail those checks. A repeated start in mid-frame must restart the CRC, the inserted transmit PEC must equal the CRC of the address and data, and bytes beyond a count of zero, or any byte with PEC disabled, must never give NAK. The alert tests check that the Alert Response Address is matched only while the alert is raised.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;

  localparam logic [7:0] PEC_POLY = 8'h07;

  // one byte of CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int i = 0; i < 8; i++) begin
      if (c[7]) c = {c[6:0], 1'b0} ^ PEC_POLY;
      else      c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  typedef struct packed {
    logic addr_evt;
    logic data_evt;
    logic rx_evt;
    logic rx_pec_evt;
    logic pec_bad;
  } pec_evt_t;

endpackage

// File: rtl/smb_pec_crc.sv
module smb_pec_crc
  import smb_pec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       upd_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= 8'h00;
    else if (clr_i) crc_q <= 8'h00;
    else if (upd_i) crc_q <= crc8_step(crc_q, data_i);
  end

  assign crc_o = crc_q;

  // R2: a start restarts the code
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == 8'h00));

  // R2: no byte, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !upd_i) |=> $stable(crc_o));
endmodule

// File: rtl/smb_pec_count.sv
module smb_pec_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load_i)                     cnt_q <= val_i;
    else if (dec_i && (cnt_q != '0))     cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);
  assign zero_o = (cnt_q == '0);

  // R3: load takes the value
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(val_i)));

  // R3: no wrap below zero
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/smb_pec_alert.sv
module smb_pec_alert #(
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alert_i,
  input  logic       addr_evt_i,
  input  logic [6:0] addr_i,
  output logic       smbalert_n_o,
  output logic       ara_match_o
);
  logic alert_q;
  logic ara_q;
  logic ara_hit;

  assign ara_hit = addr_evt_i && alert_i && (addr_i == ARA_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_q <= 1'b0;
      ara_q   <= 1'b0;
    end else begin
      alert_q <= alert_i;
      ara_q   <= ara_hit;
    end
  end

  assign smbalert_n_o = ~alert_q;
  assign ara_match_o  = ara_q;

  // R8: line follows the control one cycle late
  a_r8_alert_low: assert property (@(posedge clk) disable iff (!rst_n)
    alert_i |=> !smbalert_n_o);

  // R9: response address only answered while alerting
  a_r9_ara_needs_alert: assert property (@(posedge clk) disable iff (!rst_n)
    ara_match_o |-> $past(alert_i));
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine
  import smb_pec_pkg::*;
#(
  parameter int         CNT_W    = 8,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic             byte_dir_i,
  input  logic [7:0]       bus_byte_i,
  input  logic [7:0]       tx_data_i,
  input  logic             pec_en_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             err_clr_i,
  input  logic             alert_i,
  output logic [7:0]       tx_byte_o,
  output logic             ack_valid_o,
  output logic             nak_o,
  output logic             pec_err_o,
  output logic             smbalert_n_o,
  output logic             ara_match_o
);
  logic       addr_phase_q;
  logic [7:0] crc;
  logic       cnt_last;
  logic       cnt_zero;
  logic       pec_slot;
  logic       ack_q, nak_q, err_q;
  pec_evt_t   ev;

  // named events
  assign pec_slot      = pec_en_i && cnt_last;
  assign ev.addr_evt   = byte_valid_i && !start_i && addr_phase_q;
  assign ev.data_evt   = byte_valid_i && !start_i && !addr_phase_q;
  assign ev.rx_evt     = ev.data_evt && !byte_dir_i;
  assign ev.rx_pec_evt = ev.rx_evt && pec_slot;
  assign ev.pec_bad    = ev.rx_pec_evt && (bus_byte_i != crc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_phase_q <= 1'b0;
    else if (start_i)      addr_phase_q <= 1'b1;
    else if (byte_valid_i) addr_phase_q <= 1'b0;
  end

  smb_pec_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_i),
    .upd_i  (byte_valid_i && !start_i),
    .data_i (bus_byte_i),
    .crc_o  (crc)
  );

  smb_pec_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load_i),
    .val_i  (cnt_val_i),
    .dec_i  (ev.data_evt),
    .last_o (cnt_last),
    .zero_o (cnt_zero)
  );

  smb_pec_alert #(.ARA_ADDR(ARA_ADDR)) u_alert (
    .clk          (clk),
    .rst_n        (rst_n),
    .alert_i      (alert_i),
    .addr_evt_i   (ev.addr_evt),
    .addr_i       (bus_byte_i[7:1]),
    .smbalert_n_o (smbalert_n_o),
    .ara_match_o  (ara_match_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ack_q <= ev.rx_evt;
      nak_q <= ev.pec_bad;
      if (ev.pec_bad)      err_q <= 1'b1;
      else if (err_clr_i)  err_q <= 1'b0;
    end
  end

  assign tx_byte_o   = pec_slot ? crc : tx_data_i;
  assign ack_valid_o = ack_q;
  assign nak_o       = nak_q;
  assign pec_err_o   = err_q;

  // R5: NAK only comes with a decision
  a_r5_nak_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    nak_o |-> ack_valid_o);

  // R5, R7: NAK only on a checked PEC byte
  a_r5_nak_on_pec: assert property (@(posedge clk) disable iff (!rst_n)
    nak_o |-> $past(ev.rx_pec_evt));

  // R6: error stays until cleared
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err_o && !err_clr_i) |=> pec_err_o);

  // R6: a mismatch always lands in the flag
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    nak_o |-> pec_err_o);

  // R10: sent bytes are not acknowledged here
  a_r10_no_ack_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && byte_dir_i) |=> !ack_valid_o);

  // R3: idle count means no substitution
  a_r3_zero_no_pec: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> (tx_byte_o == tx_data_i));
endmodule

// File: tb/smb_pec_engine_bench.sv
module smb_pec_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, byte_valid_i = 1'b0, byte_dir_i = 1'b0;
  logic [7:0] bus_byte_i = 8'h00, tx_data_i = 8'h00;
  logic       pec_en_i = 1'b0, cnt_load_i = 1'b0, err_clr_i = 1'b0, alert_i = 1'b0;
  logic [7:0] cnt_val_i = 8'h00;
  logic [7:0] tx_byte_o;
  logic       ack_valid_o, nak_o, pec_err_o, smbalert_n_o, ara_match_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_crc;

  always #4 clk = ~clk;

  smb_pec_engine u_smb_pec_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
    .byte_dir_i(byte_dir_i), .bus_byte_i(bus_byte_i), .tx_data_i(tx_data_i),
    .pec_en_i(pec_en_i), .cnt_load_i(cnt_load_i), .cnt_val_i(cnt_val_i),
    .err_clr_i(err_clr_i), .alert_i(alert_i), .tx_byte_o(tx_byte_o),
    .ack_valid_o(ack_valid_o), .nak_o(nak_o), .pec_err_o(pec_err_o),
    .smbalert_n_o(smbalert_n_o), .ara_match_o(ara_match_o)
  );

  // bit-serial model: feedback = top bit xor incoming bit
  function automatic logic [7:0] model_crc(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'b0000_0111;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    ref_crc = 8'h00;
  endtask

  task automatic load(input logic [7:0] n);
    @(negedge clk);
    cnt_load_i = 1'b1; cnt_val_i = n;
    @(negedge clk);
    cnt_load_i = 1'b0;
  endtask

  // returns at the negedge after the capturing edge
  task automatic send(input logic dir, input logic [7:0] b);
    @(negedge clk);
    byte_valid_i = 1'b1; byte_dir_i = dir; bus_byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
    ref_crc = model_crc(ref_crc, b);
  endtask

  task automatic t_reset();
    check("R1 smbalert_n", {7'd0, smbalert_n_o}, 8'h01);
    check("R1 pec_err", {7'd0, pec_err_o}, 8'h00);
    check("R1 ack_valid", {7'd0, ack_valid_o}, 8'h00);
    check("R1 nak", {7'd0, nak_o}, 8'h00);
    check("R1 ara", {7'd0, ara_match_o}, 8'h00);
    tx_data_i = 8'h5A;
    #1 check("R1 tx passthrough", tx_byte_o, 8'h5A);
  endtask

  task automatic t_rx_good();
    pec_en_i = 1'b1;
    do_start();
    load(8'd4);
    send(1'b0, 8'hA0);
    check("R10 no ack on address", {7'd0, ack_valid_o}, 8'h00);
    send(1'b0, 8'h12);
    check("R5 data ack", {6'd0, ack_valid_o, nak_o}, 8'h02);
    send(1'b0, 8'h34);
    send(1'b0, 8'h56);
    send(1'b0, ref_crc);
    check("R5 R2 R3 good PEC acked", {6'd0, ack_valid_o, nak_o}, 8'h02);
    @(negedge clk);
    check("R5 ack one cycle", {7'd0, ack_valid_o}, 8'h00);
    send(1'b0, 8'hFF);
    check("R3 byte beyond zero not checked", {6'd0, ack_valid_o, nak_o}, 8'h02);
    check("R6 no error", {7'd0, pec_err_o}, 8'h00);
  endtask

  task automatic t_rx_bad();
    pec_en_i = 1'b1;
    do_start();
    load(8'd2);
    send(1'b0, 8'hB4);
    send(1'b0, 8'h77);
    send(1'b0, ref_crc ^ 8'h01);
    check("R5 bad PEC nak", {6'd0, ack_valid_o, nak_o}, 8'h03);
    check("R6 error set", {7'd0, pec_err_o}, 8'h01);
    do_start();
    load(8'd2);
    send(1'b0, 8'hB4);
    send(1'b0, 8'h01);
    send(1'b0, ref_crc);
    check("R6 error sticky over good frame", {6'd0, nak_o, pec_err_o}, 8'h01);
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    check("R6 error cleared", {7'd0, pec_err_o}, 8'h00);
  endtask

  task automatic t_tx();
    pec_en_i = 1'b1;
    do_start();
    load(8'd3);
    send(1'b0, 8'hA1);
    tx_data_i = 8'h11;
    #1 check("R4 data byte passed", tx_byte_o, 8'h11);
    send(1'b1, tx_byte_o);
    check("R10 no ack on tx", {7'd0, ack_valid_o}, 8'h00);
    tx_data_i = 8'h22;
    send(1'b1, tx_byte_o);
    tx_data_i = 8'h99;
    #1 check("R4 R2 inserted PEC", tx_byte_o, ref_crc);
    send(1'b1, tx_byte_o);
    #1 check("R3 count at zero passes data", tx_byte_o, 8'h99);
  endtask

  task automatic t_restart();
    pec_en_i = 1'b1;
    do_start();
    send(1'b0, 8'hC0);
    send(1'b0, 8'h0F);
    do_start();
    load(8'd2);
    send(1'b0, 8'hC1);
    send(1'b0, 8'h3C);
    send(1'b0, ref_crc);
    check("R2 repeated start restarts CRC", {6'd0, ack_valid_o, nak_o}, 8'h02);
  endtask

  task automatic t_disabled();
    pec_en_i = 1'b0;
    do_start();
    load(8'd2);
    send(1'b0, 8'hD0);
    send(1'b0, 8'h44);
    tx_data_i = 8'h66;
    #1 check("R7 no substitution", tx_byte_o, 8'h66);
    send(1'b0, ref_crc ^ 8'hFF);
    check("R7 no nak", {6'd0, ack_valid_o, nak_o}, 8'h02);
    check("R7 no error", {7'd0, pec_err_o}, 8'h00);
  endtask

  task automatic t_alert();
    @(negedge clk); alert_i = 1'b1;
    @(negedge clk);
    check("R8 alert low", {7'd0, smbalert_n_o}, 8'h00);
    do_start();
    send(1'b0, 8'h19);
    check("R9 ARA matched", {7'd0, ara_match_o}, 8'h01);
    @(negedge clk);
    check("R9 ARA one cycle", {7'd0, ara_match_o}, 8'h00);
    do_start();
    send(1'b0, 8'h1A);
    check("R9 other address no match", {7'd0, ara_match_o}, 8'h00);
    @(negedge clk); alert_i = 1'b0;
    @(negedge clk);
    check("R8 alert released", {7'd0, smbalert_n_o}, 8'h01);
    do_start();
    send(1'b0, 8'h18);
    check("R9 no match without alert", {7'd0, ara_match_o}, 8'h00);
  endtask

  initial begin
    ref_crc = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_good();
    t_rx_bad();
    t_tx();
    t_restart();
    t_disabled();
    t_alert();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule